// File: doc/BRIEF.md
# Dual-Mode DAC Code Interface

This block is the digital front end of an 8-bit current-output DAC. It holds the DAC code register and chooses between two ways of setting it. After power-on the block is in pulse mode. In this mode every rising edge of the serial clock pin moves the code by one step, and the code stops at full scale and at zero. As long as the data pin has stayed high, the steps only count up. The first time the data pin is seen low, the counter switches to up/down operation, and from then on the data pin sets the direction.

The first time chip select is seen low, the block switches to 3-wire serial mode. In serial mode each frame shifts a new code in, MSB first, and at the same time shifts the previous code out. Both mode switches are sticky: they hold until the next power-on reset. The shutdown pin raises a shutdown flag for the analog side. It never clears the stored code.

All pins are sampled by a free-running system clock through a synchronizer chain. Edges of the serial clock and of chip select are found in that clock domain. An input change takes effect on the system clock edge `SYNC_STAGES` cycles after the change is first sampled.

Top module: `dac_ctl_front`

## Requirements
- R1: After power-on reset the code is 0, the block is in pulse mode with counting up only, and `dout_en` is 0.
- R2: In pulse mode, while chip select stays high, each rising `sclk` edge raises the code by one as long as no low level has been seen on `din_updn`.
- R3: The first synchronized low on `din_updn` in pulse mode latches up/down operation until reset. A step taken on that same edge still counts up. After that, each step goes up when `din_updn` is 1 and down when it is 0.
- R4: Pulse steps saturate: an up step at 255 leaves 255 and a down step at 0 leaves 0.
- R5: Once `cs_n` has been seen low, the block stays in serial mode until reset, and `sclk` edges with `cs_n` high no longer change the code.
- R6: In serial mode, `din_updn` is shifted in MSB first on rising `sclk` edges while `cs_n` is low. On the rising edge of `cs_n` the code takes the shifted value only if exactly 8 bits were received in that frame; otherwise the code is unchanged.
- R7: When `cs_n` falls, `dout` presents bit 7 of the code held at that moment. Each falling `sclk` edge while `cs_n` is low advances `dout` to the next lower bit. `dout_en` is 1 only in serial mode while `cs_n` is low, and it is 0 throughout pulse mode.
- R8: `shutdown` is the inverse of the synchronized `shdn_n`. Shutdown leaves the code unchanged, and pulse stepping still works while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| sclk | input | 1 | Serial / step clock pin |
| cs_n | input | 1 | Chip select pin, active low |
| din_updn | input | 1 | Serial data in, or step direction in pulse mode |
| shdn_n | input | 1 | Shutdown request, active low |
| code | output | 8 | DAC code register |
| shutdown | output | 1 | Shutdown flag to the analog side |
| dout | output | 1 | Serial data out (old code) |
| dout_en | output | 1 | Output enable for the `dout` pad driver |

## Verification
Two events can share one sampling edge: the first low seen on `din_updn` and a rising `sclk` step. The bench provokes this by changing both pins at the same instant. It then checks that this step still counts up and that later steps follow the pin. A shutdown request is also issued while pulse steps continue, and the bench checks that the code is neither cleared nor frozen. A behavioural model runs alongside the design on every clock and judges the code, the enable, the shutdown flag and `dout`.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // one sampled pin set, oldest-first ordering is irrelevant here
  typedef struct packed {
    logic sclk;
    logic cs_n;
    logic din;
    logic shdn_n;
  } dcf_pins_t;

  localparam dcf_pins_t DCF_PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, din: 1'b1, shdn_n: 1'b1};
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dcf_step.sv
module dcf_step #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] cur,
  input  logic              up,
  output logic [CODE_W-1:0] nxt
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] BOT = '0;
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  always_comb begin
    if (up) nxt = (cur == TOP) ? TOP : cur + ONE;
    else    nxt = (cur == BOT) ? BOT : cur - ONE;
  end
endmodule

// File: rtl/dcf_serial.sv
module dcf_serial #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sel,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              din,
  input  logic [CODE_W-1:0] code_cur,
  output logic              load_v,
  output logic [CODE_W-1:0] load_data,
  output logic              dout
);
  localparam int CNT_W = $clog2(CODE_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(CODE_W + 1);

  logic [CODE_W-1:0] in_q, in_d, out_q, out_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              shift_in_en, shift_out_en;

  assign shift_in_en  = sclk_rise & sel & ~sel_fall;
  assign shift_out_en = sclk_fall & sel;

  always_comb begin
    in_d  = in_q;
    cnt_d = cnt_q;
    out_d = out_q;
    if (sel_fall) begin
      cnt_d = '0;
      out_d = code_cur;
    end else begin
      if (shift_in_en) begin
        in_d  = {in_q[CODE_W-2:0], din};
        cnt_d = (cnt_q == OVER) ? OVER : cnt_q + CNT_W'(1);
      end
      if (shift_out_en) out_d = {out_q[CODE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      cnt_q <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign load_v    = sel_rise & (cnt_q == FULL);
  assign load_data = in_q;
  assign dout      = out_q[CODE_W-1];
endmodule

// File: rtl/dac_ctl_front.sv
module dac_ctl_front #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din_updn,
  input  logic              shdn_n,
  output logic [CODE_W-1:0] code,
  output logic              shutdown,
  output logic              dout,
  output logic              dout_en
);
  import dcf_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sh_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_i = rst_sh_q[1];

  // pin synchronizers
  dcf_pins_t raw, syn;
  assign raw = '{sclk: sclk, cs_n: cs_n, din: din_updn, shdn_n: shdn_n};

  localparam int NPIN = $bits(dcf_pins_t);
  localparam logic [NPIN-1:0] IDLE_V = DCF_PINS_IDLE;
  logic [NPIN-1:0] raw_v, syn_v;
  assign raw_v = raw;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_sync
      dcf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_V[i])) u_sync (
        .clk(clk), .rst_n(rst_i), .d(raw_v[i]), .q(syn_v[i])
      );
    end
  endgenerate
  assign syn = syn_v;

  // state
  logic              p_sclk_q, p_cs_q;
  logic              serial_q, serial_d;
  logic              updn_q, updn_d;
  logic [CODE_W-1:0] code_q, code_d;

  logic sclk_rise, sclk_fall, cs_rise, cs_fall, step_en, step_up;
  logic              load_v;
  logic [CODE_W-1:0] load_data, stepped;

  assign sclk_rise = syn.sclk & ~p_sclk_q;
  assign sclk_fall = ~syn.sclk & p_sclk_q;
  assign cs_rise   = syn.cs_n & ~p_cs_q;
  assign cs_fall   = ~syn.cs_n & p_cs_q;
  assign step_en   = sclk_rise & ~serial_q & syn.cs_n;
  assign step_up   = ~updn_q | syn.din;

  dcf_step #(.CODE_W(CODE_W)) u_step (
    .cur(code_q), .up(step_up), .nxt(stepped)
  );

  dcf_serial #(.CODE_W(CODE_W)) u_serial (
    .clk(clk), .rst_n(rst_i),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sel(~syn.cs_n), .sel_fall(cs_fall), .sel_rise(cs_rise),
    .din(syn.din), .code_cur(code_q),
    .load_v(load_v), .load_data(load_data), .dout(dout)
  );

  always_comb begin
    serial_d = serial_q | ~syn.cs_n;
    updn_d   = updn_q | (~serial_q & ~syn.din);
    if (load_v)       code_d = load_data;
    else if (step_en) code_d = stepped;
    else              code_d = code_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      p_sclk_q <= 1'b0;
      p_cs_q   <= 1'b1;
      serial_q <= 1'b0;
      updn_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      p_sclk_q <= syn.sclk;
      p_cs_q   <= syn.cs_n;
      serial_q <= serial_d;
      updn_q   <= updn_d;
      code_q   <= code_d;
    end
  end

  assign code     = code_q;
  assign shutdown = ~syn.shdn_n;
  assign dout_en  = serial_q & ~syn.cs_n;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              serial_q,
  input logic              updn_q,
  input logic [CODE_W-1:0] code,
  input logic              dout_en
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  // R5
  serial_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serial_q |=> serial_q);

  // R3
  updn_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updn_q |=> updn_q);

  // R7
  pulse_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_q |-> !dout_en);

  // R2
  pulse_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_q |=> (code == $past(code)) || (code == CODE_W'($past(code) + 1'b1))
                  || (code == CODE_W'($past(code) - 1'b1)));

  // R4
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_q && code == TOP) |=> code != '0);

  // R4
  no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_q && code == '0) |=> code != TOP);
endmodule

bind dac_ctl_front dcf_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .serial_q(serial_q), .updn_q(updn_q),
  .code(code), .dout_en(dout_en)
);

// File: tb/tb_dac_ctl_front.sv
module tb_dac_ctl_front;
  localparam int S = 2;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din_updn = 1'b1, shdn_n = 1'b1;
  logic [7:0] code;
  logic shutdown, dout, dout_en;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dac_ctl_front #(.CODE_W(8), .SYNC_STAGES(S)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din_updn(din_updn),
    .shdn_n(shdn_n), .code(code), .shutdown(shutdown), .dout(dout), .dout_en(dout_en)
  );

  // behavioural reference: sample history + plain integers
  logic [3:0] hist[$];   // {sclk, cs_n, din, shdn_n}
  int  m_code, m_cnt;
  bit  m_serial, m_updn;
  logic [7:0] m_in, m_out;
  bit  m_shutdown, m_en;

  task automatic m_reset();
    hist.delete();
    for (int i = 0; i < S + 2; i++) hist.push_front(4'b0111);
    m_code = 0; m_cnt = 0; m_serial = 0; m_updn = 0;
    m_in = 8'h00; m_out = 8'h00; m_shutdown = 0; m_en = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_reset();
    else begin
      logic [3:0] cur, prv, now;
      bit rise, fall, csr, csf, step, up, old_serial;
      int old_code;
      hist.push_front({sclk, cs_n, din_updn, shdn_n});
      void'(hist.pop_back());
      cur = hist[S]; prv = hist[S+1];
      rise = cur[3] && !prv[3];
      fall = !cur[3] && prv[3];
      csr  = cur[2] && !prv[2];
      csf  = !cur[2] && prv[2];
      old_code = m_code;
      old_serial = m_serial;
      step = !m_serial && cur[2] && rise;
      up = !m_updn || cur[1];
      if (csr && m_cnt == 8) m_code = m_in;
      else if (step) m_code = up ? (m_code == 255 ? 255 : m_code + 1)
                                 : (m_code == 0 ? 0 : m_code - 1);
      if (csf) begin
        m_cnt = 0; m_out = old_code[7:0];
      end else begin
        if (rise && !cur[2]) begin
          m_in = {m_in[6:0], cur[1]};
          m_cnt = (m_cnt >= 9) ? 9 : m_cnt + 1;
        end
        if (fall && !cur[2]) m_out = {m_out[6:0], 1'b0};
      end
      if (!cur[2]) m_serial = 1;
      if (!old_serial && !cur[1]) m_updn = 1;
      now = hist[S-1];
      m_shutdown = !now[0];
      m_en = m_serial && !now[2];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && cycles > 4) begin
      check("R2,R6 model code", code, m_code);
      check("R8 model shutdown", shutdown, m_shutdown);
      check("R7 model dout_en", dout_en, m_en);
      if (m_en) check("R7 model dout", dout, m_out[7]);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wait_n(HOLD);
    sclk = 1'b0; wait_n(HOLD);
  endtask

  task automatic frame(input logic [7:0] val, input int nbits, input logic [7:0] prev);
    cs_n = 1'b0; wait_n(HOLD);
    check("R7 dout msb at select", dout, prev[7]);
    check("R7 dout_en in frame", dout_en, 1);
    for (int i = 0; i < nbits; i++) begin
      din_updn = (i < 8) ? val[7-i] : 1'b0;
      pulse();
      if (i < 7) check("R7 dout bit", dout, prev[6-i]);
    end
    cs_n = 1'b1; din_updn = 1'b1; wait_n(HOLD);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(6);
    check("R1 reset code", code, 0);
    check("R1 reset dout_en", dout_en, 0);
    check("R1 reset shutdown", shutdown, 0);

    for (int i = 0; i < 5; i++) pulse();
    check("R2 count up", code, 5);
    check("R7 pulse mode dout_en", dout_en, 0);

    din_updn = 1'b0; sclk = 1'b1; wait_n(HOLD); sclk = 1'b0; wait_n(HOLD);
    check("R3 first low step still up", code, 6);
    for (int i = 0; i < 3; i++) pulse();
    check("R3 down steps", code, 3);
    din_updn = 1'b1;
    for (int i = 0; i < 2; i++) pulse();
    check("R3 up after updn latch", code, 5);

    din_updn = 1'b0;
    for (int i = 0; i < 10; i++) pulse();
    check("R4 floor at zero", code, 0);
    din_updn = 1'b1;
    for (int i = 0; i < 260; i++) pulse();
    check("R4 ceiling at 255", code, 255);

    shdn_n = 1'b0; wait_n(HOLD);
    check("R8 shutdown asserted", shutdown, 1);
    check("R8 code retained", code, 255);
    din_updn = 1'b0; pulse(); din_updn = 1'b1; wait_n(1);
    check("R8 stepping during shutdown", code, 254);
    shdn_n = 1'b1; wait_n(HOLD);
    check("R8 shutdown released", shutdown, 0);

    frame(8'hA5, 8, 8'd254);
    check("R6 eight-bit load", code, 8'hA5);
    frame(8'h3C, 7, 8'hA5);
    check("R6 short frame ignored", code, 8'hA5);
    frame(8'h3C, 9, 8'hA5);
    check("R6 long frame ignored", code, 8'hA5);

    for (int i = 0; i < 3; i++) pulse();
    check("R5 no steps in serial mode", code, 8'hA5);
    check("R7 dout_en off when deselected", dout_en, 0);

    frame(8'h0F, 8, 8'hA5);
    check("R6 second load", code, 8'h0F);

    wait_n(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule